// File: doc/BRIEF.md
# Time-Shared Halfband Decimation Cascade

This block lowers the rate of a stream of signed fixed-point samples by 2^S, where S is the stage count. Each of the S stages is a halfband lowpass that keeps every second result. All stages share one folded multiply-accumulate engine. Samples that share a coefficient are added before they are multiplied. Taps whose value is zero are skipped. The centre tap is a shift, not a multiply. Each stage keeps its own short history window, and a finished result from one stage is written into the history of the next stage. The default build uses nine stages, so the total ratio is 1/512, for example 64 kHz in and 125 Hz out.

Input uses a valid/ready handshake. A sample is taken on every rising edge where `in_valid` and `in_ready` are both high. `in_ready` goes low only while stage 0 holds two samples that the engine has not yet consumed. The source must then hold its sample and `in_valid` until `in_ready` returns. The output has no ready. A result is present for exactly the one cycle in which `out_valid` is high. A scheduler starts a stage only when that stage has two new samples and the next stage has room for its result. When several stages qualify, the lowest-numbered stage goes first. Because of this rule, no stage history is ever overwritten before it has been used.

Top module: `hbd_cascade`

## Requirements
- R1: While reset is high, and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1. Reset clears every history word to zero and every pending count to zero.
- R2: After reset, the k-th output appears only after k·2^S samples have been accepted. No output appears before the first 2^S samples have been accepted.
- R3: Each stage works on its window x[n]..x[n-6], with x[n] the newest sample, and produces one result for every two samples written into it. The accumulator value is 16384·x[n-3] + 9216·(x[n-2]+x[n-4]) − 1024·(x[n]+x[n-6]). The stage result is (acc + 16384) >>> 15, which rounds half up, saturated to the signed 16-bit range. Stage histories start from zero after reset, and the output must match this cascade bit for bit.
- R4: With a constant input c, the output settles to exactly c, because the coefficients sum to unity.
- R5: If a weighted sum exceeds the 16-bit range, the stage result is clamped to 32767 or −32768 and never wraps.
- R6: Once stage 0 holds two unconsumed samples, `in_ready` is 0 in the next cycle. No accepted sample is lost or duplicated.
- R7: The engine never writes a result into a stage that already holds two unconsumed samples. Under input offered on every cycle, the output still matches R3.
- R8: A reset asserted in the middle of a stream discards all earlier history. Afterwards the outputs match a cascade that starts from zero.
- R9: `out_valid` is high for single cycles only, never on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Stage 0 can take a sample |
| in_data | input | DW | Signed input sample |
| out_valid | output | 1 | One-cycle strobe for a decimated result |
| out_data | output | DW | Signed decimated result |

## Verification
If a history word is corrupted, or a stage is scheduled while its neighbour is full, the final output no longer matches the zero-initialised reference cascade. The error shows within the next output or two, because every final result depends on the last few windows of every stage. A pending count that is wrong shows up as a shift in the output count against the accepted-sample count, or as `in_ready` going low at the wrong time, which the next handshake exposes. Saturation or rounding faults change single output values and are caught by the bit-exact comparison.

// File: rtl/hbd_pkg.sv
package hbd_pkg;
  // coefficient width, Q(CW-1) fixed point
  localparam int CW    = 16;
  // number of symmetric coefficient pairs on non-zero side taps
  localparam int NPAIR = 2;
  // full window length and centre position
  localparam int TAPS  = 4*NPAIR - 1;
  localparam int CTR   = 2*NPAIR - 1;

  // pair k weights taps 2k and TAPS-1-2k
  function automatic logic signed [CW-1:0] side_coef(input int k);
    case (k)
      0:       return CW'(-1024);
      default: return CW'(9216);
    endcase
  endfunction

  typedef enum logic [1:0] {ENG_IDLE, ENG_MAC, ENG_FIN} eng_state_e;
endpackage

// File: rtl/hbd_history.sv
module hbd_history
  import hbd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSTG = 9
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSTG-1:0]      wr_en,
  input  logic signed [DW-1:0] wr_data [NSTG],
  input  logic [NSTG-1:0]      take,
  output logic [1:0]           cnt     [NSTG],
  output logic signed [DW-1:0] tap_new [NSTG][NPAIR],
  output logic signed [DW-1:0] tap_old [NSTG][NPAIR],
  output logic signed [DW-1:0] tap_mid [NSTG]
);
  logic signed [DW-1:0] hist [NSTG][TAPS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < NSTG; s++) begin
        cnt[s] <= 2'd0;
        for (int j = 0; j < TAPS; j++) hist[s][j] <= '0;
      end
    end else begin
      for (int s = 0; s < NSTG; s++) begin
        if (wr_en[s]) begin
          hist[s][0] <= wr_data[s];
          for (int j = 1; j < TAPS; j++) hist[s][j] <= hist[s][j-1];
          cnt[s] <= cnt[s] + 2'd1;
        end else if (take[s]) begin
          cnt[s] <= 2'd0;
        end
      end
    end
  end

  // only the non-zero taps leave the bank
  always_comb begin
    for (int s = 0; s < NSTG; s++) begin
      tap_mid[s] = hist[s][CTR];
      for (int k = 0; k < NPAIR; k++) begin
        tap_new[s][k] = hist[s][2*k];
        tap_old[s][k] = hist[s][TAPS-1-2*k];
      end
    end
  end
endmodule

// File: rtl/hbd_sched.sv
module hbd_sched #(
  parameter int NSTG = 9,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic [1:0]    cnt [NSTG],
  input  logic          idle,
  output logic          pick_vld,
  output logic [SW-1:0] pick_stg
);
  logic [NSTG-1:0] elig;

  for (genvar s = 0; s < NSTG; s++) begin : g_elig
    if (s == NSTG-1) begin : g_last
      assign elig[s] = (cnt[s] == 2'd2);
    end else begin : g_mid
      assign elig[s] = (cnt[s] == 2'd2) && (cnt[s+1] != 2'd2);
    end
  end

  // descending scan: the lowest eligible stage is kept
  always_comb begin
    pick_vld = 1'b0;
    pick_stg = '0;
    for (int s = NSTG-1; s >= 0; s--) begin
      if (elig[s]) begin
        pick_vld = idle;
        pick_stg = SW'(s);
      end
    end
  end
endmodule

// File: rtl/hbd_engine.sv
module hbd_engine
  import hbd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSTG = 9,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 pick_vld,
  input  logic [SW-1:0]        pick_stg,
  input  logic signed [DW-1:0] tap_new [NSTG][NPAIR],
  input  logic signed [DW-1:0] tap_old [NSTG][NPAIR],
  input  logic signed [DW-1:0] tap_mid [NSTG],
  output logic                 idle,
  output logic                 fin,
  output logic [SW-1:0]        fin_stg,
  output logic signed [DW-1:0] res
);
  localparam int AW = DW + CW + 4;
  localparam int PW = DW + CW + 1;
  localparam int KW = (NPAIR > 1) ? $clog2(NPAIR) : 1;
  localparam logic signed [AW-1:0] SMAX = AW'(2**(DW-1) - 1);
  localparam logic signed [AW-1:0] SMIN = -SMAX - AW'(1);

  eng_state_e           st;
  logic [KW-1:0]        k;
  logic [SW-1:0]        stg;
  logic signed [AW-1:0] acc;
  logic signed [DW:0]   pre;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] rnd;

  // fold the pair, then one multiply
  always_comb begin
    pre  = {tap_new[stg][k][DW-1], tap_new[stg][k]}
         + {tap_old[stg][k][DW-1], tap_old[stg][k]};
    prod = PW'(pre) * PW'(side_coef(int'(k)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ENG_IDLE;
      k   <= '0;
      stg <= '0;
      acc <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (pick_vld) begin
          stg <= pick_stg;
          acc <= AW'(tap_mid[pick_stg]) <<< (CW-2);
          k   <= '0;
          st  <= ENG_MAC;
        end
        ENG_MAC: begin
          acc <= acc + AW'(prod);
          k   <= k + KW'(1);
          if (k == KW'(NPAIR-1)) st <= ENG_FIN;
        end
        default: st <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    rnd = (acc + (AW'(1) <<< (CW-2))) >>> (CW-1);
    if (rnd > SMAX)      res = SMAX[DW-1:0];
    else if (rnd < SMIN) res = SMIN[DW-1:0];
    else                 res = rnd[DW-1:0];
  end

  assign idle    = (st == ENG_IDLE);
  assign fin     = (st == ENG_FIN);
  assign fin_stg = stg;
endmodule

// File: rtl/hbd_cascade.sv
module hbd_cascade
  import hbd_pkg::*;
#(
  parameter int DW   = 16,
  parameter int NSTG = 9,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic signed [DW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [DW-1:0] out_data
);
  logic [NSTG-1:0]      wr_en;
  logic signed [DW-1:0] wr_data [NSTG];
  logic [NSTG-1:0]      take;
  logic [1:0]           cnt     [NSTG];
  logic signed [DW-1:0] tap_new [NSTG][NPAIR];
  logic signed [DW-1:0] tap_old [NSTG][NPAIR];
  logic signed [DW-1:0] tap_mid [NSTG];
  logic                 idle, fin, pick_vld;
  logic [SW-1:0]        pick_stg, fin_stg;
  logic signed [DW-1:0] res;

  assign in_ready = (cnt[0] != 2'd2);

  for (genvar s = 0; s < NSTG; s++) begin : g_route
    if (s == 0) begin : g_head
      assign wr_en[s]   = in_valid && in_ready;
      assign wr_data[s] = in_data;
    end else begin : g_link
      assign wr_en[s]   = fin && (fin_stg == SW'(s-1));
      assign wr_data[s] = res;
    end
    assign take[s] = fin && (fin_stg == SW'(s));
  end

  hbd_history #(.DW(DW), .NSTG(NSTG)) u_hist (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .take(take),
    .cnt(cnt), .tap_new(tap_new), .tap_old(tap_old), .tap_mid(tap_mid)
  );

  hbd_sched #(.NSTG(NSTG)) u_sched (
    .cnt(cnt), .idle(idle), .pick_vld(pick_vld), .pick_stg(pick_stg)
  );

  hbd_engine #(.DW(DW), .NSTG(NSTG)) u_eng (
    .clk(clk), .rst(rst), .pick_vld(pick_vld), .pick_stg(pick_stg),
    .tap_new(tap_new), .tap_old(tap_old), .tap_mid(tap_mid),
    .idle(idle), .fin(fin), .fin_stg(fin_stg), .res(res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= fin && (fin_stg == SW'(NSTG-1));
      if (fin && (fin_stg == SW'(NSTG-1))) out_data <= res;
    end
  end
endmodule

// File: rtl/hbd_cascade_chk.sv
module hbd_cascade_chk #(
  parameter int NSTG = 9,
  localparam int SW  = (NSTG > 1) ? $clog2(NSTG) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          out_valid,
  input logic [1:0]    cnt [NSTG],
  input logic          fin,
  input logic [SW-1:0] fin_stg
);
  logic nxt_full;
  always_comb begin
    nxt_full = 1'b0;
    for (int s = 0; s < NSTG-1; s++)
      if (fin_stg == SW'(s)) nxt_full = (cnt[s+1] == 2'd2);
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!out_valid && in_ready));

  p_fill_stall_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && cnt[0] == 2'd1) |=> !in_ready);

  p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
    cnt[0] != 2'd3);

  p_no_overwrite_r7: assert property (@(posedge clk) disable iff (rst)
    fin |-> !nxt_full);

  p_single_strobe_r9: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);
endmodule

bind hbd_cascade hbd_cascade_chk #(.NSTG(NSTG)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .cnt(cnt), .fin(fin), .fin_stg(fin_stg)
);

// File: tb/tb_hbd_cascade.sv
module tb_hbd_cascade;
  localparam int CLK_PERIOD = 10;
  localparam int TB_STG     = 4;
  localparam int DW         = 16;
  localparam int RATIO      = 1 << TB_STG;

  logic                 clk = 1'b0;
  logic                 rst = 1'b1;
  logic                 in_valid = 1'b0;
  logic                 in_ready;
  logic signed [DW-1:0] in_data = '0;
  logic                 out_valid;
  logic signed [DW-1:0] out_data;

  hbd_cascade #(.DW(DW), .NSTG(TB_STG)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, fails = 0;
  int got_q[$], exp_q[$];
  int m_hist [TB_STG][7];
  int m_cnt  [TB_STG];
  bit out_prev = 1'b0;
  int pulse_viol = 0, bp_seen = 0;

  always @(negedge clk) begin
    if (!rst && out_valid) got_q.push_back(int'(out_data));
    if (!rst && out_valid && out_prev) pulse_viol++;
    if (!rst && in_valid && !in_ready) bp_seen++;
    out_prev = out_valid && !rst;
  end

  task automatic check(string req, int got, int expv);
    checks++;
    if (got != expv) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, got, expv);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < TB_STG; s++) begin
      m_cnt[s] = 0;
      for (int j = 0; j < 7; j++) m_hist[s][j] = 0;
    end
  endtask

  // zero-initialised reference cascade built from the R3 formula
  task automatic model_push(int x);
    int v;
    longint acc, r;
    v = x;
    for (int s = 0; s < TB_STG; s++) begin
      for (int j = 6; j > 0; j--) m_hist[s][j] = m_hist[s][j-1];
      m_hist[s][0] = v;
      m_cnt[s]++;
      if (m_cnt[s] < 2) return;
      m_cnt[s] = 0;
      acc = 16384 * longint'(m_hist[s][3])
          + 9216 * longint'(m_hist[s][2] + m_hist[s][4])
          - 1024 * longint'(m_hist[s][0] + m_hist[s][6]);
      r = (acc + 16384) >>> 15;
      if (r > 32767) r = 32767;
      if (r < -32768) r = -32768;
      v = int'(r);
    end
    exp_q.push_back(v);
  endtask

  function automatic int gen(int mode, int i);
    logic [31:0] h;
    h = i * 32'd1103515245 + 32'd12345;
    case (mode)
      0: return 1000;
      1: return int'($signed(h[23:8]));
      2: return ((i % 8 == 1) || (i % 8 == 7)) ? -32768 : 32767;
      3: return ((i % 8 == 1) || (i % 8 == 7)) ? 32767 : -32768;
      default: return ((i * 97) % 40000) - 20000;
    endcase
  endfunction

  task automatic send(int x);
    in_valid = 1'b1;
    in_data  = DW'(x);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    model_push(x);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic compare_all(string req);
    int n;
    repeat (80) @(negedge clk);
    check({req, " output count"}, got_q.size(), exp_q.size());
    n = (got_q.size() < exp_q.size()) ? got_q.size() : exp_q.size();
    for (int i = 0; i < n; i++) check(req, got_q[i], exp_q[i]);
  endtask

  task automatic run(string req, int mode, int n, int gap);
    for (int i = 0; i < n; i++) begin
      send(gen(mode, i));
      repeat (gap) @(negedge clk);
    end
    compare_all(req);
  endtask

  task automatic t_reset();
    check("R1 out_valid in reset", int'(out_valid), 0);
    check("R1 in_ready in reset", int'(in_ready), 1);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    check("R1 out_valid after reset", int'(out_valid), 0);
    check("R1 in_ready after reset", int'(in_ready), 1);
  endtask

  task automatic t_fill();
    do_reset();
    for (int i = 0; i < RATIO-1; i++) send(gen(4, i));
    repeat (80) @(negedge clk);
    check("R2 no output before fill", got_q.size(), 0);
    send(gen(4, RATIO-1));
    repeat (80) @(negedge clk);
    check("R2 one output after fill", got_q.size(), 1);
    if (got_q.size() == 1) check("R2 first value", got_q[0], exp_q[0]);
  endtask

  task automatic t_dc();
    do_reset();
    run("R3 dc", 0, RATIO*12, 1);
    if (got_q.size() > 0) check("R4 dc settle", got_q[got_q.size()-1], 1000);
    else check("R4 dc settle", -1, 1000);
  endtask

  task automatic t_rand();
    do_reset();
    run("R3 random", 1, RATIO*20, 2);
  endtask

  task automatic t_sat();
    do_reset();
    run("R5 clamp high", 2, RATIO*8, 1);
    do_reset();
    run("R5 clamp low", 3, RATIO*8, 1);
  endtask

  task automatic t_backpressure();
    do_reset();
    bp_seen = 0;
    run("R7 full-rate input", 1, RATIO*16, 0);
    check("R6 ready dropped", int'(bp_seen > 0), 1);
  endtask

  task automatic t_midreset();
    do_reset();
    for (int i = 0; i < 37; i++) send(gen(1, i));
    do_reset();
    run("R8 after mid reset", 4, RATIO*6, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    t_fill();
    t_dc();
    t_rand();
    t_sat();
    t_backpressure();
    t_midreset();
    check("R9 single-cycle strobe", pulse_viol, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule